// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Port

This block holds the interrupt priority and vector logic for one peripheral port on a serial priority chain. A condition detector sends it a one-cycle request pulse. The block then pulls its active-low interrupt line low. It also takes the enable that comes down the chain from the device of higher priority, and it drives the enable that goes on to the device of lower priority. When the processor acknowledges an interrupt (the M1 and IORQ strobes active together), the port that is selected puts its 8-bit vector on the data bus. A port is selected when its incoming enable is high and its own request blocks the outgoing enable.

The block watches every opcode fetch on the data bus. When it sees the two-byte return-from-interrupt sequence, it ends its under-service state. A port that has a request waiting, but not yet acknowledged, lets the outgoing enable pass for one fetch after the prefix byte. This way only the port that is really under service accepts the return. Because each port clears only on a return seen while its incoming enable is high, nested services unwind in priority order. All strobes are active-high and synchronous to `clk`.

Top module: `daisy_irq_port`

## Requirements
- R1: After reset there is no request pending and no service in progress. `intN` is 1, `vecOe` is 0, and `ieo` follows `iei`.
- R2: A `reqPulse` taken while `m1` is low makes the request pending from the next clock. `intN` is then 0 while `iei` is 1, and `intN` is 1 while `iei` is 0.
- R3: The pending state never becomes set while `m1` is high. A `reqPulse` that arrives during `m1` is held, and it becomes pending on the first clock edge that sees `m1` low.
- R4: An acknowledge window is `m1` and `iorq` both 1. If a window opens while `iei` is 1 and a request is pending, `vecOut` equals `vectorIn` and `vecOe` is 1 for the whole window. The request is then cleared, so `intN` goes to 1, and the port becomes under service.
- R5: Outside the prefix window of R10, `ieo` is 1 exactly when `iei` is 1 and the port is neither pending nor under service.
- R6: An acknowledge window seen while `iei` is 0 does not drive the bus (`vecOe` stays 0) and leaves the request pending.
- R7: An opcode fetch is `m1` = 1 with `iorq` = 0, and its byte is the last `dataIn` seen during that fetch. A fetch of 8'hED followed by a fetch of 8'h4D, both seen while `iei` is 1, ends the under-service state when the second fetch ends.
- R8: A return sequence that completes while `iei` is 0 leaves the under-service state unchanged.
- R9: Any byte other than 8'h4D after 8'hED resets the decoder. A lone 8'h4D fetch that comes afterwards does not end the service.
- R10: A port that is pending and not under service drives `ieo` equal to `iei` from the end of an 8'hED fetch to the end of the next fetch. A port under service keeps `ieo` at 0 during that time.
- R11: `iorq` cycles without `m1` are not fetches. Their bytes do not advance the return decoder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPulse | input | 1 | One-cycle request from the port condition detector |
| m1 | input | 1 | Opcode-fetch / acknowledge phase strobe |
| iorq | input | 1 | I/O request strobe |
| iei | input | 1 | Enable in, from the higher-priority neighbour |
| dataIn | input | 8 | Data bus as seen by the port (opcode snoop) |
| vectorIn | input | 8 | Vector value of this port |
| intN | output | 1 | Active-low interrupt request (open-drain style) |
| ieo | output | 1 | Enable out, to the lower-priority neighbour |
| vecOut | output | 8 | Vector driven during acknowledge, zero otherwise |
| vecOe | output | 1 | Bus drive enable for `vecOut` |

## Verification
Some rules are checked by assertions on every cycle. The pending state never rises during `m1`. The vector is driven only inside an acknowledge window with `iei` high. `ieo` is never high while the port is under service. `intN` is never low with `iei` low. The service state ends only on a decoded return seen with `iei` high. Other behaviour depends on how fetch bytes follow one another, so only the bench scenarios can show it. This covers the prefix window that releases `ieo` for exactly one following fetch, the decoder reset on a wrong second byte, and `iorq`-only cycles being ignored. The bench also sweeps all 256 vector values through a full request, acknowledge and return cycle.

// File: rtl/daisy_irq_pkg.sv
package daisy_irq_pkg;
  typedef struct packed {
    logic inAck;
    logic ackStrobe;
    logic retiHit;
    logic edArmed;
  } ctrlStrobeT;

  typedef enum logic [0:0] {DEC_IDLE = 1'b0, DEC_GOT_PREFIX = 1'b1} decStateT;
endpackage

// File: rtl/daisy_irq_ctrl.sv
module daisy_irq_ctrl
  import daisy_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RET_PREFIX = 8'hED,
  parameter logic [DATA_W-1:0] RET_SUFFIX = 8'h4D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m1,
  input  logic              iorq,
  input  logic              iei,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              pending,
  output ctrlStrobeT        strobes
);
  logic              fetchPrev;
  logic              ackPrev;
  logic [DATA_W-1:0] opLatch;
  decStateT          decState;
  logic              fetchNow;
  logic              fetchEnd;

  assign fetchNow = m1 && !iorq;
  assign fetchEnd = fetchPrev && !m1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPrev <= 1'b0;
      ackPrev   <= 1'b0;
      opLatch   <= '0;
      decState  <= DEC_IDLE;
    end else begin
      fetchPrev <= fetchNow;
      ackPrev   <= m1 && iorq;
      if (fetchNow) opLatch <= dataIn;
      if (fetchEnd) begin
        if (opLatch == RET_PREFIX) decState <= DEC_GOT_PREFIX;
        else                       decState <= DEC_IDLE;
      end
    end
  end

  always_comb begin
    strobes.inAck     = m1 && iorq;
    strobes.ackStrobe = m1 && iorq && !ackPrev && iei && pending;
    strobes.retiHit   = fetchEnd && (decState == DEC_GOT_PREFIX) && (opLatch == RET_SUFFIX);
    strobes.edArmed   = (decState == DEC_GOT_PREFIX);
  end

  // R10: the prefix window only opens at the end of a fetch
  a_r10_arm_at_fetch_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.edArmed) |-> $past(fetchPrev && !m1));
  // R11: an iorq-only cycle never ends a fetch
  a_r11_no_fetch_on_io: assert property (@(posedge clk) disable iff (!rstN)
    (iorq && !m1) |=> !(fetchPrev));
endmodule

// File: rtl/daisy_irq_dp.sv
module daisy_irq_dp
  import daisy_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqPulse,
  input  logic              m1,
  input  logic              iei,
  input  logic [DATA_W-1:0] vectorIn,
  input  ctrlStrobeT        strobes,
  output logic              pending,
  output logic              intN,
  output logic              ieo,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecOe
);
  logic reqHeld;
  logic underService;
  logic grantHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqHeld      <= 1'b0;
      pending      <= 1'b0;
      underService <= 1'b0;
      grantHold    <= 1'b0;
    end else begin
      if (strobes.ackStrobe) begin
        pending      <= 1'b0;
        underService <= 1'b1;
        if (reqPulse) reqHeld <= 1'b1;
      end else if (!m1 && (reqPulse || reqHeld)) begin
        pending <= 1'b1;
        reqHeld <= 1'b0;
      end else if (reqPulse) begin
        reqHeld <= 1'b1;
      end
      if (strobes.retiHit && iei) underService <= 1'b0;
      if (strobes.ackStrobe)      grantHold <= 1'b1;
      else if (!strobes.inAck)    grantHold <= 1'b0;
    end
  end

  always_comb begin
    intN   = !(pending && iei);
    ieo    = iei && !underService && (!pending || strobes.edArmed);
    vecOe  = strobes.inAck && iei && (strobes.ackStrobe || grantHold);
    vecOut = vecOe ? vectorIn : '0;
  end

  // R3: request status frozen while m1 is high
  a_r3_no_rise_in_m1: assert property (@(posedge clk) disable iff (!rstN)
    m1 |=> !$rose(pending));
  // R4: vector only inside an enabled acknowledge window
  a_r4_vec_in_window: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> (strobes.inAck && iei));
  // R5: chain blocked while under service
  a_r5_block_in_service: assert property (@(posedge clk) disable iff (!rstN)
    underService |-> !ieo);
  // R2: interrupt line needs the incoming enable
  a_r2_int_needs_iei: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> iei);
  // R7: service ends only on a return seen with iei high
  a_r7_clear_on_return: assert property (@(posedge clk) disable iff (!rstN)
    $fell(underService) |-> $past(strobes.retiHit && iei));
endmodule

// File: rtl/daisy_irq_port.sv
module daisy_irq_port
  import daisy_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RET_PREFIX = 8'hED,
  parameter logic [DATA_W-1:0] RET_SUFFIX = 8'h4D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqPulse,
  input  logic              m1,
  input  logic              iorq,
  input  logic              iei,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] vectorIn,
  output logic              intN,
  output logic              ieo,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecOe
);
  ctrlStrobeT strobes;
  logic       pending;

  daisy_irq_ctrl #(.DATA_W(DATA_W), .RET_PREFIX(RET_PREFIX), .RET_SUFFIX(RET_SUFFIX)) ctrl_i (
    .clk(clk), .rstN(rstN), .m1(m1), .iorq(iorq), .iei(iei),
    .dataIn(dataIn), .pending(pending), .strobes(strobes)
  );

  daisy_irq_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .m1(m1), .iei(iei),
    .vectorIn(vectorIn), .strobes(strobes), .pending(pending),
    .intN(intN), .ieo(ieo), .vecOut(vecOut), .vecOe(vecOe)
  );
endmodule

// File: tb/daisy_irq_port_tb.sv
module daisy_irq_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqPulse = 1'b0;
  logic       m1 = 1'b0;
  logic       iorq = 1'b0;
  logic       iei = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] vectorIn = 8'h00;
  logic       intN, ieo, vecOe;
  logic [7:0] vecOut;
  int         nChecks = 0;
  int         nFails = 0;

  always #2 clk = ~clk;

  daisy_irq_port dut_i (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .m1(m1), .iorq(iorq),
    .iei(iei), .dataIn(dataIn), .vectorIn(vectorIn),
    .intN(intN), .ieo(ieo), .vecOut(vecOut), .vecOe(vecOe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; m1 = 0; iorq = 0; reqPulse = 0; iei = 1; dataIn = 0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic request();
    reqPulse = 1'b1; tick(); reqPulse = 1'b0; tick();
  endtask

  task automatic fetch(input logic [7:0] b);
    m1 = 1'b1; iorq = 1'b0; dataIn = b;
    tick(); tick();
    m1 = 1'b0; dataIn = 8'h00;
    tick();
  endtask

  // Acknowledge window of three cycles; expOe/expVec checked in each cycle
  task automatic ackWindow(input string req, input int expOe, input int expVec);
    m1 = 1'b1; iorq = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(req, vecOe, expOe);
      chk(req, vecOut, expVec);
      tick();
    end
    m1 = 1'b0; iorq = 1'b0;
    tick();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 intN", intN, 1); chk("R1 vecOe", vecOe, 0); chk("R1 ieo", ieo, 1);
    iei = 0; #1; chk("R1 ieo follows iei", ieo, 0); iei = 1; tick();

    // R2 request and iei gating
    request();
    chk("R2 intN low", intN, 0); chk("R5 ieo pending", ieo, 0);
    iei = 0; #1; chk("R2 intN gated", intN, 1); tick();

    // R6 acknowledge with iei low
    ackWindow("R6 no drive", 0, 0);
    iei = 1; #1; chk("R6 still pending", intN, 0); tick();

    // R4 acknowledge with iei high
    vectorIn = 8'hA5;
    ackWindow("R4 vector", 1, 8'hA5);
    chk("R4 int released", intN, 1); chk("R5 ieo in service", ieo, 0);

    // R9 wrong second byte resets decoder
    fetch(8'hED); fetch(8'h00); chk("R9 after ED,00", ieo, 0);
    fetch(8'h4D); chk("R9 lone suffix", ieo, 0);
    // R11 iorq-only bytes ignored
    iorq = 1; dataIn = 8'hED; tick(); iorq = 0; tick();
    fetch(8'h4D); chk("R11 io cycle ignored", ieo, 0);
    // R8 return with iei low
    iei = 0; fetch(8'hED); fetch(8'h4D); iei = 1; #1;
    chk("R8 no clear iei low", ieo, 0); tick();
    // R10 under service keeps ieo low after prefix
    fetch(8'hED); chk("R10 service blocks", ieo, 0);
    fetch(8'h4D); chk("R7 cleared", ieo, 1);

    // R3 request during m1 held
    doReset();
    m1 = 1; dataIn = 8'h00; reqPulse = 1; tick(); reqPulse = 0;
    chk("R3 no int in m1", intN, 1); tick();
    chk("R3 still held", intN, 1);
    m1 = 0; tick();
    chk("R3 pending after m1", intN, 0);

    // R10 prefix window for pending unacknowledged port
    chk("R10 before", ieo, 0);
    fetch(8'hED); chk("R10 open", ieo, 1);
    m1 = 1; dataIn = 8'h4D; tick(); chk("R10 open in next fetch", ieo, 1);
    m1 = 0; tick(); chk("R10 closed", ieo, 0);
    chk("R10 still pending", intN, 0);

    // R4/R7 sweep over every vector value
    for (int v = 0; v < 256; v++) begin
      doReset();
      vectorIn = 8'(v);
      request();
      chk("R2 sweep int", intN, 0);
      ackWindow("R4 sweep", 1, v);
      chk("R5 sweep blocked", ieo, 0);
      fetch(8'hED); fetch(8'h4D);
      chk("R7 sweep cleared", ieo, 1);
      chk("R1 sweep idle oe", vecOe, 0);
    end

    report();
    $finish;
  end
endmodule